// File: doc/BRIEF.md
# Binary64 to Signed Integer Converter

This block turns an IEEE 754 double-precision operand into a signed two's complement integer of either 64 or 32 bits. The rounding direction comes from a 2-bit mode field held in the floating point status register. Alongside the integer, the block raises an invalid indication when the operand cannot be represented as an integer of the chosen width.

The datapath has two register stages. The first stage decodes the operand and aligns its significand into an integer part plus a guard bit and a sticky bit. The second stage applies the rounding increment, checks the range and negates the magnitude for negative inputs. A request presented with `in_valid` is answered two clock edges later with `out_valid`, and a new request may be issued on every cycle. Updating exception registers and conversion in the opposite direction are handled elsewhere.

Top module: `dbl2int_conv`

## Requirements
- R1: A request accepted with `in_valid` high at a rising edge produces `out_valid` high exactly two rising edges later. A cycle without a request produces `out_valid` low two edges later. Back-to-back requests are answered in order.
- R2: With `in_rm` = 0, the value is rounded to the nearest integer, and exact halves go to the even neighbour (6.4→6, 6.8→7, 6.5→6, 7.5→8, -2.5→-2).
- R3: With `in_rm` = 1, the value is rounded toward zero (7.1→7, -2.3→-2).
- R4: With `in_rm` = 2, the value is rounded toward plus infinity (4.2→5, -3.9→-3).
- R5: With `in_rm` = 3, the value is rounded toward minus infinity (4.2→4, -3.9→-4).
- R6: An operand whose 11-bit exponent field (bits 62:52) is all ones, meaning an infinity or any NaN, sets `out_invalid`.
- R7: `out_invalid` is set when the rounded value lies outside the signed range of the selected width. The range is [-2^63, 2^63-1] for 64 bits and [-2^31, 2^31-1] for 32 bits. Both exact lower limits are valid results.
- R8: When `out_invalid` is set, `out_result` is the most positive integer of the selected width: 64'h7FFF_FFFF_FFFF_FFFF, or 64'h0000_0000_7FFF_FFFF when `in_narrow` = 1.
- R9: `in_narrow` = 1 selects a 32-bit destination. The result occupies bits 31:0 in two's complement, and bits 63:32 are zero.
- R10: Zero (of either sign) converts to 0 in every mode. A nonzero subnormal converts to 0, except that a positive one gives +1 under mode 2 and a negative one gives -1 under mode 3.
- R11: While `rst_n` is low, `out_valid`, `out_result` and `out_invalid` are all zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Request strobe |
| in_op | input | 64 | Binary64 operand |
| in_narrow | input | 1 | 1 = 32-bit destination, 0 = 64-bit |
| in_rm | input | 2 | Rounding mode: 0 nearest-even, 1 toward zero, 2 toward +inf, 3 toward -inf |
| out_valid | output | 1 | Result strobe, two cycles after the request |
| out_result | output | 64 | Converted integer, or the saturation value when invalid |
| out_invalid | output | 1 | Operand not representable in the selected width |

## Verification
The properties assume that `in_valid` and the operand fields are known, stable values at every rising edge once reset is released. They also assume that each request is fully described by the inputs on its own cycle, with no dependence on earlier requests. The bench drives all inputs on falling edges from a single process and holds `in_valid` low throughout reset. Its random operands are weighted toward the exponent bands where behaviour changes: subnormals, exact halves, the 2^31 and 2^63 boundaries, and all-ones exponents. These are mixed with idle cycles so that both latency properties are exercised.

// File: rtl/dbl2int_pkg.sv
package dbl2int_pkg;

    typedef enum logic [1:0] {
        RM_NEAREST = 2'd0,
        RM_TRUNC   = 2'd1,
        RM_CEIL    = 2'd2,
        RM_FLOOR   = 2'd3
    } rmode_e;

endpackage

// File: rtl/dbl2int_unpack.sv
// Classifies the operand and aligns the significand into a fixed-point
// window: integer magnitude, one guard bit and an OR of all lower bits.
module dbl2int_unpack #(
    parameter int EXP_W = 11,
    parameter int MAN_W = 52,
    parameter int INT_W = 64
) (
    input  logic [EXP_W+MAN_W:0] op,
    output logic                 sign,
    output logic                 special,
    output logic                 too_big,
    output logic [INT_W-1:0]     mag,
    output logic                 guard,
    output logic                 sticky
);
    localparam int BIAS      = (1 << (EXP_W - 1)) - 1;
    localparam int FIX_W     = 2 * INT_W;
    localparam int SH_W      = $clog2(FIX_W) + 1;
    localparam int SHIFT_OFS = INT_W - MAN_W;

    logic [EXP_W-1:0] ef;
    logic [MAN_W-1:0] mf;
    int               unb;
    logic [SH_W-1:0]  sh;
    logic [FIX_W-1:0] fixed;

    always_comb begin
        sign    = op[EXP_W+MAN_W];
        ef      = op[EXP_W+MAN_W-1:MAN_W];
        mf      = op[MAN_W-1:0];
        unb     = int'(ef) - BIAS;
        special = 1'b0;
        too_big = 1'b0;
        mag     = '0;
        guard   = 1'b0;
        sticky  = 1'b0;
        sh      = '0;
        fixed   = '0;
        if (&ef) begin
            special = 1'b1;
        end else if (ef == '0) begin
            sticky = |mf;                   // subnormal: below one half
        end else if (unb < -1) begin
            sticky = 1'b1;                  // below one half, nonzero
        end else if (unb >= INT_W) begin
            too_big = 1'b1;
        end else begin
            // leading one lands at bit INT_W+unb of the window
            sh     = SH_W'(unb + SHIFT_OFS);
            fixed  = {{(FIX_W-MAN_W-1){1'b0}}, 1'b1, mf} << sh;
            mag    = fixed[FIX_W-1:INT_W];
            guard  = fixed[INT_W-1];
            sticky = |fixed[INT_W-2:0];
        end
    end
endmodule

// File: rtl/dbl2int_round.sv
// Chooses the rounding increment from mode, sign, guard and sticky.
module dbl2int_round #(
    parameter int INT_W = 64
) (
    input  logic [1:0]       rm,
    input  logic             sign,
    input  logic [INT_W-1:0] mag,
    input  logic             guard,
    input  logic             sticky,
    output logic [INT_W:0]   rounded
);
    import dbl2int_pkg::*;

    logic inc;
    logic inexact;

    always_comb begin
        inexact = guard | sticky;
        case (rmode_e'(rm))
            RM_NEAREST: inc = guard & (sticky | mag[0]);
            RM_TRUNC:   inc = 1'b0;
            RM_CEIL:    inc = ~sign & inexact;
            RM_FLOOR:   inc = sign & inexact;
            default:    inc = 1'b0;
        endcase
        rounded = {1'b0, mag} + (INT_W+1)'(inc);
    end
endmodule

// File: rtl/dbl2int_pack.sv
// Range check against the selected width, negation and saturation.
module dbl2int_pack #(
    parameter int INT_W = 64
) (
    input  logic             sign,
    input  logic             special,
    input  logic             too_big,
    input  logic             narrow,
    input  logic [INT_W:0]   rounded,
    output logic [INT_W-1:0] result,
    output logic             invalid
);
    localparam int HALF = INT_W / 2;

    logic [INT_W:0]   lim_pos;
    logic             over;
    logic [INT_W-1:0] twos;

    always_comb begin
        lim_pos = '0;
        if (narrow) lim_pos[HALF-2:0]  = '1;
        else        lim_pos[INT_W-2:0] = '1;
        over    = sign ? (rounded > lim_pos + (INT_W+1)'(1)) : (rounded > lim_pos);
        twos    = sign ? (~rounded[INT_W-1:0] + INT_W'(1)) : rounded[INT_W-1:0];
        invalid = special | too_big | over;
        if (invalid)     result = lim_pos[INT_W-1:0];
        else if (narrow) result = {{HALF{1'b0}}, twos[HALF-1:0]};
        else             result = twos;
    end
endmodule

// File: rtl/dbl2int_conv.sv
module dbl2int_conv #(
    parameter int EXP_W = 11,
    parameter int MAN_W = 52,
    parameter int INT_W = 64
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 in_valid,
    input  logic [EXP_W+MAN_W:0] in_op,
    input  logic                 in_narrow,
    input  logic [1:0]           in_rm,
    output logic                 out_valid,
    output logic [INT_W-1:0]     out_result,
    output logic                 out_invalid
);
    typedef struct packed {
        logic             vld;
        logic             sign;
        logic             special;
        logic             too_big;
        logic             narrow;
        logic [1:0]       rm;
        logic [INT_W-1:0] mag;
        logic             guard;
        logic             sticky;
    } align_t;

    typedef struct packed {
        logic             vld;
        logic [INT_W-1:0] res;
        logic             inv;
    } final_t;

    align_t a_d, a_q;
    final_t b_d, b_q;

    logic             u_sign, u_special, u_too_big, u_guard, u_sticky;
    logic [INT_W-1:0] u_mag;
    logic [INT_W:0]   r_rounded;
    logic [INT_W-1:0] p_result;
    logic             p_invalid;

    dbl2int_unpack #(.EXP_W(EXP_W), .MAN_W(MAN_W), .INT_W(INT_W)) u_unpack (
        .op(in_op), .sign(u_sign), .special(u_special), .too_big(u_too_big),
        .mag(u_mag), .guard(u_guard), .sticky(u_sticky)
    );

    dbl2int_round #(.INT_W(INT_W)) u_round (
        .rm(a_q.rm), .sign(a_q.sign), .mag(a_q.mag), .guard(a_q.guard),
        .sticky(a_q.sticky), .rounded(r_rounded)
    );

    dbl2int_pack #(.INT_W(INT_W)) u_pack (
        .sign(a_q.sign), .special(a_q.special), .too_big(a_q.too_big),
        .narrow(a_q.narrow), .rounded(r_rounded), .result(p_result),
        .invalid(p_invalid)
    );

    always_comb begin
        a_d     = a_q;
        a_d.vld = in_valid;
        if (in_valid) begin
            a_d.sign    = u_sign;
            a_d.special = u_special;
            a_d.too_big = u_too_big;
            a_d.narrow  = in_narrow;
            a_d.rm      = in_rm;
            a_d.mag     = u_mag;
            a_d.guard   = u_guard;
            a_d.sticky  = u_sticky;
        end
        b_d     = b_q;
        b_d.vld = a_q.vld;
        if (a_q.vld) begin
            b_d.res = p_result;
            b_d.inv = p_invalid;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            a_q <= '0;
            b_q <= '0;
        end else begin
            a_q <= a_d;
            b_q <= b_d;
        end
    end

    assign out_valid   = b_q.vld;
    assign out_result  = b_q.res;
    assign out_invalid = b_q.inv;
endmodule

// File: rtl/dbl2int_conv_chk.sv
module dbl2int_conv_chk #(
    parameter int EXP_W = 11,
    parameter int MAN_W = 52,
    parameter int INT_W = 64
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic                 in_valid,
    input logic [EXP_W+MAN_W:0] in_op,
    input logic                 in_narrow,
    input logic [1:0]           in_rm,
    input logic                 out_valid,
    input logic [INT_W-1:0]     out_result,
    input logic                 out_invalid
);
    localparam int HALF = INT_W / 2;
    localparam logic [INT_W-1:0] POS_WIDE   = {1'b0, {(INT_W-1){1'b1}}};
    localparam logic [INT_W-1:0] POS_NARROW = {{(HALF+1){1'b0}}, {(HALF-1){1'b1}}};

    a_r1_req_latency: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |-> ##2 out_valid);

    a_r1_idle_latency: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |-> ##2 !out_valid);

    a_r6_special_invalid: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && (&in_op[EXP_W+MAN_W-1:MAN_W])) |-> ##2 out_invalid);

    a_r8_saturate_value: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && out_invalid) |-> (out_result == POS_WIDE || out_result == POS_NARROW));

    a_r9_narrow_high_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_narrow) |-> ##2 (out_result[INT_W-1:HALF] == '0));

    a_r10_zero_operand: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_op[EXP_W+MAN_W-1:0] == '0) |-> ##2 (out_result == '0 && !out_invalid));

    a_r11_reset_quiet: assert property (@(posedge clk)
        !rst_n |=> (!out_valid && out_result == '0 && !out_invalid));

    logic unused_rm;
    assign unused_rm = ^in_rm;
endmodule

bind dbl2int_conv dbl2int_conv_chk #(.EXP_W(EXP_W), .MAN_W(MAN_W), .INT_W(INT_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_op(in_op),
    .in_narrow(in_narrow), .in_rm(in_rm), .out_valid(out_valid),
    .out_result(out_result), .out_invalid(out_invalid)
);

// File: tb/sim_dbl2int_conv.sv
module sim_dbl2int_conv;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic [63:0] in_op = '0;
    logic        in_narrow = 1'b0;
    logic [1:0]  in_rm = '0;
    logic        out_valid;
    logic [63:0] out_result;
    logic        out_invalid;

    int n_cmp = 0;
    int n_bad = 0;

    bit          qv [2];
    logic [63:0] qr [2];
    bit          qi [2];
    string       qt [2];

    always #2 clk = ~clk;   // 250 MHz

    dbl2int_conv u0 (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_op(in_op),
        .in_narrow(in_narrow), .in_rm(in_rm), .out_valid(out_valid),
        .out_result(out_result), .out_invalid(out_invalid)
    );

    // Reference model on real arithmetic, straight from R2..R10.
    function automatic void ref_conv(input logic [63:0] b, input logic [1:0] rm,
                                     input bit nar, output logic [63:0] res,
                                     output bit inv, output string tag);
        real r, f, d, t, hi;
        longint v;
        if (&b[62:52]) begin
            inv = 1'b1;
            res = nar ? 64'h0000_0000_7FFF_FFFF : 64'h7FFF_FFFF_FFFF_FFFF;
            tag = "R6 R8";
            return;
        end
        r = $bitstoreal(b);
        case (rm)
            2'd0: begin
                f = $floor(r);
                d = r - f;
                if (d > 0.5)      t = f + 1.0;
                else if (d < 0.5) t = f;
                else begin
                    v = longint'(f);
                    t = v[0] ? f + 1.0 : f;
                end
            end
            2'd1: t = (r < 0.0) ? $ceil(r) : $floor(r);
            2'd2: t = $ceil(r);
            default: t = $floor(r);
        endcase
        hi  = nar ? 2147483648.0 : 9223372036854775808.0;
        inv = (t >= hi) || (t < -hi);
        if (inv) begin
            res = nar ? 64'h0000_0000_7FFF_FFFF : 64'h7FFF_FFFF_FFFF_FFFF;
            tag = "R7 R8";
        end else begin
            v   = longint'(t);
            res = nar ? {32'h0, v[31:0]} : v;
            if (nar)              tag = "R9";
            else if (b[62:52] == 0) tag = "R10";
            else case (rm)
                2'd0: tag = "R2";
                2'd1: tag = "R3";
                2'd2: tag = "R4";
                default: tag = "R5";
            endcase
        end
    endfunction

    task automatic step(input logic [63:0] b, input logic [1:0] rm,
                        input bit nar, input bit v);
        logic [63:0] er;
        bit          ei;
        string       et;
        @(negedge clk);
        n_cmp++;
        if (out_valid !== qv[1]) begin
            n_bad++;
            $display("FAIL R1 out_valid got %0b exp %0b", out_valid, qv[1]);
        end
        if (qv[1]) begin
            n_cmp++;
            if (out_result !== qr[1] || out_invalid !== qi[1]) begin
                n_bad++;
                $display("FAIL %s result got %h/%0b exp %h/%0b",
                         qt[1], out_result, out_invalid, qr[1], qi[1]);
            end
        end
        qv[1] = qv[0]; qr[1] = qr[0]; qi[1] = qi[0]; qt[1] = qt[0];
        in_valid  = v;
        in_op     = b;
        in_rm     = rm;
        in_narrow = nar;
        ref_conv(b, rm, nar, er, ei, et);
        qv[0] = v; qr[0] = er; qi[0] = ei; qt[0] = et;
    endtask

    task automatic dir(input real x, input logic [1:0] rm, input bit nar);
        step($realtobits(x), rm, nar, 1'b1);
    endtask

    function automatic logic [63:0] rand_op();
        logic [63:0] b;
        int k;
        b[63]    = 1'($urandom % 2);
        b[51:0]  = {$urandom, $urandom} & 64'h000F_FFFF_FFFF_FFFF;
        if ($urandom % 4 == 0) b[39:0] = '0;           // exact halves likely
        k = int'($urandom % 16);
        if (k == 0)      begin b[62:52] = '0; if ($urandom % 3 == 0) b[51:0] = '0; end
        else if (k == 1) b[62:52] = '1;
        else if (k == 2) b[62:52] = 11'(1023 + 61 + int'($urandom % 4));
        else if (k == 3) b[62:52] = 11'(1023 + 29 + int'($urandom % 4));
        else             b[62:52] = 11'(1023 - 3 + int'($urandom % 60));
        return b;
    endfunction

    initial begin
        void'($urandom(32'd20240611));
        for (int i = 0; i < 2; i++) begin qv[i] = 0; qr[i] = '0; qi[i] = 0; qt[i] = ""; end
        repeat (3) @(negedge clk);
        n_cmp++;
        if (out_valid !== 1'b0 || out_result !== 64'h0 || out_invalid !== 1'b0) begin
            n_bad++;
            $display("FAIL R11 reset outputs got %0b/%h/%0b exp 0/0/0",
                     out_valid, out_result, out_invalid);
        end
        rst_n = 1'b1;

        // R2..R5 worked examples
        dir(6.4, 0, 0); dir(6.8, 0, 0); dir(6.5, 0, 0); dir(7.5, 0, 0);
        dir(-2.5, 0, 0); dir(0.5, 0, 0); dir(-0.5, 0, 0); dir(1.5, 0, 0);
        dir(7.1, 1, 0); dir(-2.3, 1, 0);
        dir(4.2, 2, 0); dir(-3.9, 2, 0);
        dir(4.2, 3, 0); dir(-3.9, 3, 0);
        // R6 specials
        step(64'h7FF0_0000_0000_0000, 0, 0, 1);
        step(64'hFFF0_0000_0000_0000, 1, 1, 1);
        step(64'h7FF8_0000_0000_0000, 2, 0, 1);
        step(64'h7FF0_0000_0000_0001, 3, 1, 1);
        // R7 boundaries
        dir(9223372036854775808.0, 1, 0);
        dir(-9223372036854775808.0, 0, 0);
        step(64'hC3E0_0000_0000_0001, 1, 0, 1);
        dir(9223372036854774784.0, 2, 0);
        dir(2147483647.5, 0, 1);
        dir(2147483647.5, 1, 1);
        dir(-2147483648.5, 0, 1);
        dir(-2147483648.5, 3, 1);
        dir(-2147483648.0, 1, 1);
        // R9 narrow negatives
        dir(-5.7, 1, 1); dir(-1.0, 3, 1);
        // R10 zero and subnormals
        step(64'h0000_0000_0000_0000, 3, 0, 1);
        step(64'h8000_0000_0000_0000, 2, 0, 1);
        step(64'h0000_0000_0000_0001, 2, 0, 1);
        step(64'h8000_0000_0000_0001, 3, 0, 1);
        step(64'h8000_0000_0000_0001, 0, 0, 1);
        step(64'h000F_FFFF_FFFF_FFFF, 1, 0, 1);

        for (int i = 0; i < 3000; i++)
            step(rand_op(), 2'($urandom % 4), ($urandom % 3) == 0, ($urandom % 5) != 0);

        step('0, 0, 0, 0);
        step('0, 0, 0, 0);
        step('0, 0, 0, 0);
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog expired");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule